// File: doc/BRIEF.md
# Byte-Writable Pipelined Burst SRAM

This block is a single-port synchronous static memory with a 32-bit data path split into four byte lanes and a parameterised depth of 1K words by default. Every control, address and write-data input is registered on the rising clock edge. A read is pipelined through an output register. A write completes internally on the edge that follows its capture, with no handshake. A write covers any subset of the byte lanes, or all four lanes through a global write input that overrides the lane selection.

An external burst address source drives the address together with an access strobe. Three chip selects must all be active for an access to be taken. A sleep input powers the array down. Once sleep is released, the block waits out a fixed wake-up period before it accepts accesses again. An asynchronous output-enable input gates only the read-valid flag. A low read-valid flag stands for a high-impedance data bus.

Top module: `bytewise_pipe_sram`

## Requirements
- R1: An accepted read of address A, captured on edge N, shows the word at A on `rdata_o` after edge N+1. `rd_valid_o` is high from that point when `oe_n_i` is low. A write never raises `rd_valid_o`.
- R2: When `bwr_en_n_i` is low and `wr_all_n_i` is high, the access is a write of the lanes whose `lane_n_i` bits are low. Bit 0 selects data bits 7:0, bit 1 selects 15:8, bit 2 selects 23:16 and bit 3 selects 31:24. Unselected lanes keep their contents.
- R3: With `wr_all_n_i` high, the access is a read if `bwr_en_n_i` is high, whatever `lane_n_i` holds. It is also a read if every bit of `lane_n_i` is high.
- R4: A low `wr_all_n_i` writes all four lanes, regardless of `bwr_en_n_i` and `lane_n_i`.
- R5: An access is taken only on an edge where `strobe_i` is high, `sel_a_n_i` is low, `sel_b_i` is high and `sel_c_n_i` is low. Otherwise nothing is written and `rd_valid_o` stays low for it.
- R6: Accesses are ignored on any edge where `sleep_i` is high. They are also ignored on the first three edges after `sleep_i` returns low, and are taken again from the fourth. An access already captured is dropped if `sleep_i` is high on its execution edge.
- R7: `rd_valid_o` equals the internal read-valid flag ANDed with a low `oe_n_i`, with no clock in between. `oe_n_i` never alters contents. `rdata_o` holds its value on edges that execute no read.
- R8: After reset, `rd_valid_o` is low and the block is awake, ready to accept an access.
- R9: A read captured on the edge right after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Power-down request, active high |
| sel_a_n_i | input | 1 | Chip select, active low |
| sel_b_i | input | 1 | Chip select, active high |
| sel_c_n_i | input | 1 | Chip select, active low |
| strobe_i | input | 1 | Start-of-access strobe |
| addr_i | input | AW (10) | Word address |
| wr_all_n_i | input | 1 | Global write of all lanes, active low |
| bwr_en_n_i | input | 1 | Qualifier for the lane enables, active low |
| lane_n_i | input | 4 | Per-lane write enables, active low |
| wdata_i | input | 32 | Write data |
| oe_n_i | input | 1 | Output enable, active low, asynchronous |
| rdata_o | output | 32 | Registered read data |
| rd_valid_o | output | 1 | Read data valid and driven; low means high impedance |

## Verification
The assertions take for granted that `sleep_i` and the control inputs are steady around each rising edge. They also assume that, coming out of reset, `sleep_i` is low, so the wake-up counter starts from its idle value. The stimulus changes every input on the falling edge, keeps `sleep_i` low through reset, and issues accesses one at a time except in the deliberate back-to-back write-then-read case. The in-flight drop under sleep is guarded by its requirement but is not driven by the stimulus.

// File: rtl/bwsram_pkg.sv
package bwsram_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/bwsram_wake.sv
module bwsram_wake #(
  parameter int unsigned WAKE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(WAKE_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (sleep_i)
      cnt_d = CW'(WAKE_CYC);
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ready_o = (cnt_q == '0) && !sleep_i;

  // R6: counter never exceeds the wake-up period
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(WAKE_CYC));
  // R6: the cycle in which sleep drops is still inside the wake-up window
  p_wake_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_i) |-> !ready_o);
endmodule

// File: rtl/bwsram_capture.sv
module bwsram_capture
  import bwsram_pkg::*;
#(
  parameter int unsigned AW    = 10,
  parameter int unsigned LANES = 4,
  localparam int unsigned DW   = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready_i,
  input  logic             sel_ok_i,
  input  logic             strobe_i,
  input  logic             wr_all_n_i,
  input  logic             bwr_en_n_i,
  input  logic [LANES-1:0] lane_n_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output op_e              op_o,
  output logic [LANES-1:0] mask_o,
  output logic [AW-1:0]    addr_o,
  output logic [DW-1:0]    wdata_o
);
  logic             accept;
  logic             is_wr;
  logic [LANES-1:0] mask_d;
  op_e              op_d, op_q;
  logic [LANES-1:0] mask_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;

  always_comb begin
    accept = strobe_i && sel_ok_i && ready_i;
    if (!wr_all_n_i)
      mask_d = '1;
    else if (!bwr_en_n_i)
      mask_d = ~lane_n_i;
    else
      mask_d = '0;
    is_wr = (mask_d != '0);
    if (!accept)
      op_d = OP_IDLE;
    else if (is_wr)
      op_d = OP_WRITE;
    else
      op_d = OP_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) op_q <= OP_IDLE;
    else        op_q <= op_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      mask_q  <= mask_d;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  assign op_o    = op_q;
  assign mask_o  = mask_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;

  // R6: nothing is captured while asleep or waking
  p_no_capture_asleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_i |=> op_q == OP_IDLE);
  // R2: a captured write always selects at least one lane
  p_write_has_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_WRITE) |-> (mask_q != '0));
endmodule

// File: rtl/bwsram_array.sv
module bwsram_array
  import bwsram_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned LANES = 4,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned DW   = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we_i && mask_i[g])
        mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = mem[addr_i];
  end
endmodule

// File: rtl/bwsram_out.sv
module bwsram_out #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_exec_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvld_o
);
  logic          rvld_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvld_q <= 1'b0;
    else        rvld_q <= rd_exec_i;
  end

  always_ff @(posedge clk) begin
    if (rd_exec_i) rdata_q <= rdata_i;
  end

  assign rdata_o = rdata_q;
  assign rvld_o  = rvld_q;

  // R7: output data only changes on an edge that executes a read
  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_exec_i |=> $stable(rdata_o));
endmodule

// File: rtl/bytewise_pipe_sram.sv
module bytewise_pipe_sram
  import bwsram_pkg::*;
#(
  parameter int unsigned DEPTH    = 1024,
  parameter int unsigned WAKE_CYC = 3,
  localparam int unsigned AW      = $clog2(DEPTH),
  localparam int unsigned LANES   = 4,
  localparam int unsigned DW      = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_i,
  input  logic             sel_a_n_i,
  input  logic             sel_b_i,
  input  logic             sel_c_n_i,
  input  logic             strobe_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_all_n_i,
  input  logic             bwr_en_n_i,
  input  logic [LANES-1:0] lane_n_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             oe_n_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rd_valid_o
);
  logic             rst_meta_q, rst_n_s;
  logic             ready;
  logic             sel_ok;
  op_e              op;
  logic [LANES-1:0] mask;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [DW-1:0]    arr_rdata;
  logic             we, rd_exec, rvld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  assign sel_ok = !sel_a_n_i && sel_b_i && !sel_c_n_i;

  bwsram_wake #(.WAKE_CYC(WAKE_CYC)) i_wake (
    .clk(clk), .rst_n(rst_n_s), .sleep_i(sleep_i), .ready_o(ready)
  );

  bwsram_capture #(.AW(AW), .LANES(LANES)) i_capture (
    .clk(clk), .rst_n(rst_n_s), .ready_i(ready), .sel_ok_i(sel_ok),
    .strobe_i(strobe_i), .wr_all_n_i(wr_all_n_i), .bwr_en_n_i(bwr_en_n_i),
    .lane_n_i(lane_n_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .op_o(op), .mask_o(mask), .addr_o(addr_q), .wdata_o(wdata_q)
  );

  assign we      = (op == OP_WRITE) && !sleep_i;
  assign rd_exec = (op == OP_READ)  && !sleep_i;

  bwsram_array #(.DEPTH(DEPTH), .LANES(LANES)) i_array (
    .clk(clk), .we_i(we), .mask_i(mask), .addr_i(addr_q),
    .wdata_i(wdata_q), .rdata_o(arr_rdata)
  );

  bwsram_out #(.DW(DW)) i_out (
    .clk(clk), .rst_n(rst_n_s), .rd_exec_i(rd_exec),
    .rdata_i(arr_rdata), .rdata_o(rdata_o), .rvld_o(rvld)
  );

  assign rd_valid_o = rvld && !oe_n_i;

  // R5: a deselected edge captures no access
  p_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    !sel_ok |=> op == OP_IDLE);
  // R1: an executed read is visible at the port one edge later unless output is disabled
  p_read_latency_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op == OP_READ && !sleep_i) |=> (rd_valid_o || oe_n_i));
  // R1: a write never produces valid read data
  p_write_no_valid_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op == OP_WRITE) |=> !rvld);
endmodule

// File: tb/test_bytewise_pipe_sram.sv
module test_bytewise_pipe_sram;
  localparam int unsigned AW = 10;

  typedef struct packed {
    logic        wa_n;
    logic        bw_n;
    logic [3:0]  ln_n;
    logic [9:0]  adr;
    logic [31:0] dat;
    logic        chk;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 4'hF, 10'd5,    32'h11223344, 1'b0, 32'h0},
    '{1'b1, 1'b1, 4'hF, 10'd5,    32'h0,        1'b1, 32'h11223344},
    '{1'b1, 1'b0, 4'hE, 10'd5,    32'hAABBCCDD, 1'b0, 32'h0},
    '{1'b1, 1'b1, 4'hF, 10'd5,    32'h0,        1'b1, 32'h112233DD},
    '{1'b1, 1'b0, 4'h5, 10'd5,    32'h55667788, 1'b0, 32'h0},
    '{1'b1, 1'b1, 4'hF, 10'd5,    32'h0,        1'b1, 32'h552277DD},
    '{1'b1, 1'b1, 4'h0, 10'd5,    32'hFFFFFFFF, 1'b1, 32'h552277DD},
    '{1'b0, 1'b1, 4'hF, 10'd1023, 32'hCAFEF00D, 1'b0, 32'h0},
    '{1'b1, 1'b1, 4'hF, 10'd1023, 32'h0,        1'b1, 32'hCAFEF00D},
    '{1'b0, 1'b0, 4'hE, 10'd0,    32'h0BADBEEF, 1'b0, 32'h0},
    '{1'b1, 1'b1, 4'hF, 10'd0,    32'h0,        1'b1, 32'h0BADBEEF},
    '{1'b1, 1'b0, 4'hF, 10'd0,    32'h12345678, 1'b1, 32'h0BADBEEF}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sleep_i, sel_a_n_i, sel_b_i, sel_c_n_i, strobe_i;
  logic [AW-1:0] addr_i;
  logic          wr_all_n_i, bwr_en_n_i;
  logic [3:0]    lane_n_i;
  logic [31:0]   wdata_i;
  logic          oe_n_i;
  logic [31:0]   rdata_o;
  logic          rd_valid_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bytewise_pipe_sram i_bytewise_pipe_sram (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .sel_a_n_i(sel_a_n_i),
    .sel_b_i(sel_b_i), .sel_c_n_i(sel_c_n_i), .strobe_i(strobe_i),
    .addr_i(addr_i), .wr_all_n_i(wr_all_n_i), .bwr_en_n_i(bwr_en_n_i),
    .lane_n_i(lane_n_i), .wdata_i(wdata_i), .oe_n_i(oe_n_i),
    .rdata_o(rdata_o), .rd_valid_o(rd_valid_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    strobe_i   = 1'b0;
    sel_a_n_i  = 1'b0;
    sel_b_i    = 1'b1;
    sel_c_n_i  = 1'b0;
    wr_all_n_i = 1'b1;
    bwr_en_n_i = 1'b1;
    lane_n_i   = 4'hF;
    addr_i     = '0;
    wdata_i    = '0;
  endtask

  task automatic drive(input logic wa, input logic bw, input logic [3:0] ln,
                       input logic [9:0] a, input logic [31:0] d);
    strobe_i   = 1'b1;
    wr_all_n_i = wa;
    bwr_en_n_i = bw;
    lane_n_i   = ln;
    addr_i     = a;
    wdata_i    = d;
  endtask

  // drive at a falling edge, capture, execute, return at the falling edge after execution
  task automatic access(input logic wa, input logic bw, input logic [3:0] ln,
                        input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    drive(wa, bw, ln, a, d);
    @(negedge clk);
    idle();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    rst_n   = 1'b0;
    sleep_i = 1'b0;
    oe_n_i  = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: reset state
    check(rd_valid_o == 1'b0, "R8 valid low after reset", 32'(rd_valid_o), 32'h0);

    // vector walk: R1 R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wa_n, VEC[i].bw_n, VEC[i].ln_n, VEC[i].adr, VEC[i].dat);
      if (VEC[i].chk) begin
        check(rd_valid_o == 1'b1, $sformatf("R1 R3 vec%0d valid", i), 32'(rd_valid_o), 32'h1);
        check(rdata_o == VEC[i].exp, $sformatf("R2 R4 vec%0d data", i), rdata_o, VEC[i].exp);
      end else begin
        check(rd_valid_o == 1'b0, $sformatf("R1 vec%0d write no valid", i), 32'(rd_valid_o), 32'h0);
      end
    end

    // R5: each select inactive in turn, plus strobe low
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      drive(1'b0, 1'b1, 4'hF, 10'd5, 32'hFFFFFFFF);
      if (k == 0) sel_a_n_i = 1'b1;
      if (k == 1) sel_b_i   = 1'b0;
      if (k == 2) sel_c_n_i = 1'b1;
      if (k == 3) strobe_i  = 1'b0;
      @(negedge clk);
      idle();
      @(negedge clk);
    end
    @(negedge clk);
    drive(1'b1, 1'b1, 4'hF, 10'd5, 32'h0);
    sel_b_i = 1'b0;
    @(negedge clk);
    idle();
    @(negedge clk);
    check(rd_valid_o == 1'b0, "R5 deselected read no valid", 32'(rd_valid_o), 32'h0);
    access(1'b1, 1'b1, 4'hF, 10'd5, 32'h0);
    check(rdata_o == 32'h552277DD, "R5 contents unchanged", rdata_o, 32'h552277DD);

    // R7: output enable gates valid asynchronously
    oe_n_i = 1'b1;
    access(1'b1, 1'b1, 4'hF, 10'd0, 32'h0);
    check(rd_valid_o == 1'b0, "R7 valid gated by oe", 32'(rd_valid_o), 32'h0);
    #1 oe_n_i = 1'b0;
    #0.5;
    check(rd_valid_o == 1'b1, "R7 valid follows oe", 32'(rd_valid_o), 32'h1);
    check(rdata_o == 32'h0BADBEEF, "R7 data under oe", rdata_o, 32'h0BADBEEF);
    repeat (3) @(negedge clk);
    check(rdata_o == 32'h0BADBEEF, "R7 data held while idle", rdata_o, 32'h0BADBEEF);
    check(rd_valid_o == 1'b0, "R7 valid drops when idle", 32'(rd_valid_o), 32'h0);

    // R9: write followed at once by read of the same word
    @(negedge clk);
    drive(1'b0, 1'b1, 4'hF, 10'd9, 32'h99999999);
    @(negedge clk);
    drive(1'b1, 1'b1, 4'hF, 10'd9, 32'h0);
    @(negedge clk);
    idle();
    @(negedge clk);
    check(rd_valid_o == 1'b1, "R9 back-to-back valid", 32'(rd_valid_o), 32'h1);
    check(rdata_o == 32'h99999999, "R9 back-to-back data", rdata_o, 32'h99999999);

    // R6: sleep and wake-up window
    access(1'b0, 1'b1, 4'hF, 10'd7, 32'h00007777);
    @(negedge clk);
    sleep_i = 1'b1;
    drive(1'b1, 1'b1, 4'hF, 10'd7, 32'h0);
    @(negedge clk);
    idle();
    @(negedge clk);
    check(rd_valid_o == 1'b0, "R6 read during sleep ignored", 32'(rd_valid_o), 32'h0);
    sleep_i = 1'b0;
    drive(1'b0, 1'b1, 4'hF, 10'd7, 32'h00000001);
    @(negedge clk);
    idle();
    @(negedge clk);
    drive(1'b1, 1'b1, 4'hF, 10'd7, 32'h0);
    @(negedge clk);
    drive(1'b1, 1'b1, 4'hF, 10'd7, 32'h0);
    @(negedge clk);
    idle();
    check(rd_valid_o == 1'b0, "R6 third wake edge ignored", 32'(rd_valid_o), 32'h0);
    @(negedge clk);
    check(rd_valid_o == 1'b1, "R6 fourth wake edge accepted", 32'(rd_valid_o), 32'h1);
    check(rdata_o == 32'h00007777, "R6 write in wake window ignored", rdata_o, 32'h00007777);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule